// File: doc/BRIEF.md
# Register File with Call Scrubbing

This block holds the architectural registers of a small 64-bit, two-operand RISC engine: ten general registers R0 to R9 and a frame-pointer register R10 that software cannot write. Two combinational read ports and one write port serve the execution pipeline. A write either replaces all 64 bits or replaces the low 32 bits and zero-fills the rest. A write and a read of the same register in the same cycle give the reader the new value.

Each general register has a defined flag. When an external function call completes, R0 takes the returned value and the argument registers R1 to R5 are cleared to zero and marked undefined. The callee-saved registers R6 to R9 keep their values and flags. A program-start event puts the context argument into R1 and marks every other general register undefined. Any enabled read of an undefined register raises a one-cycle fault. An attempt to write R10 or an unmapped address raises a separate one-cycle fault. An exit request treats R0 as the exit value and checks that it is defined.

Top module: `call_reg_file`

## Requirements
- R1: During and after reset, with no request, `readFault` and `writeFault` are 0, every general register is undefined and holds zero, and reading address 10 returns the `frameBase` value sampled during reset.
- R2: A full write (`wrLow`=0) to address 0..9 makes that register defined, and a read of that address from the next cycle returns all 64 bits of `wrData` with no fault.
- R3: A subregister write (`wrLow`=1) stores `wrData[31:0]` in bits 31:0 and zeros in bits 63:32, and marks the register defined.
- R4: A write to address 10..15 changes no register, and `writeFault` is 1 in the cycle after the write request and 0 otherwise. Address 10 keeps returning `frameBase`.
- R5: An enabled read (`rdEnA` or `rdEnB`) of an undefined register sets `readFault` to 1 in the following cycle. A read of the same address with its enable low leaves `readFault` at 0.
- R6: When `callDone` is high, then from the next cycle R0 holds `callRet` and is defined, and R1..R5 read as zero and are undefined.
- R7: R6..R9 keep their data and defined flags across a call completion.
- R8: When `startValid` is high, then from the next cycle R1 holds `startCtx` and is defined, and all other general registers are undefined with unchanged data.
- R9: Events take priority in the order start, then call completion, then the write port. A write request in a cycle with `startValid` or `callDone` high is dropped.
- R10: When the write port and a read port name the same general register in one cycle, and the write is accepted, the read returns the value being written (zero-extended for a subregister write) and raises no fault.
- R11: `exitValue` always shows R0. When `exitReq` is high, `readFault` is 1 in the next cycle exactly when R0 is undefined.
- R12: A read of address 11..15 returns zero and always counts as a read of an undefined register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameBase | input | 64 | Frame-pointer value loaded into R10 during reset |
| startValid | input | 1 | Program-start event |
| startCtx | input | 64 | Context argument placed in R1 at start |
| callDone | input | 1 | Function-call completion event |
| callRet | input | 64 | Value returned by the completed call |
| wrEn | input | 1 | Write request |
| wrLow | input | 1 | 1: 32-bit zero-extending write, 0: full 64-bit write |
| wrAddr | input | 4 | Write address |
| wrData | input | 64 | Write data |
| rdEnA | input | 1 | Read port A is in use |
| rdAddrA | input | 4 | Read port A address |
| rdDataA | output | 64 | Read port A data |
| rdEnB | input | 1 | Read port B is in use |
| rdAddrB | input | 4 | Read port B address |
| rdDataB | output | 64 | Read port B data |
| exitReq | input | 1 | Exit request; R0 is the exit value |
| exitValue | output | 64 | Current content of R0 |
| readFault | output | 1 | One-cycle flag: an enabled read found an undefined register |
| writeFault | output | 1 | One-cycle flag: a write targeted a non-writable address |

## Verification
The hardest state to reach is a cycle where events and ordinary traffic overlap: a write that collides with a call completion or a start, or a start that collides with a call. In those cycles the losing request must leave no trace in the data or in the defined flags. The stimulus first fills every register through full-width and subregister sweeps over all sixteen addresses, so each flag is set. It then fires the colliding requests and reads every address back through both ports, comparing against a bench model that applies only the winning event. The same sweeps cover same-cycle forwarding for every general register and exit checks with R0 both defined and undefined.

// File: rtl/crf_pkg.sv
`timescale 1ns/1ps
package crf_pkg;
  parameter int unsigned GPR_COUNT = 10;
  parameter int unsigned ADDR_W    = 4;
  localparam int unsigned FP_IDX   = GPR_COUNT;
  localparam int unsigned RET_IDX  = 0;
  localparam int unsigned CTX_IDX  = 1;
  localparam int unsigned ARG_LO   = 1;
  localparam int unsigned ARG_HI   = 5;
  localparam int unsigned KEEP_LO  = ARG_HI + 1;
  localparam int unsigned KEEP_HI  = GPR_COUNT - 1;

  // strobes from control to datapath
  typedef struct packed {
    logic startGo;
    logic callGo;
    logic wrGo;
    logic wrLow;
    logic fwdA;
    logic fwdB;
  } strobe_t;
endpackage

// File: rtl/crf_ctrl.sv
`timescale 1ns/1ps
module crf_ctrl
  import crf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              callDone,
  input  logic              wrEn,
  input  logic              wrLow,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEnA,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic              rdEnB,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              exitReq,
  output strobe_t           strobe,
  output logic              readFault,
  output logic              writeFault
);
  localparam logic [GPR_COUNT-1:0] ONE_HOT0 = GPR_COUNT'(1);
  localparam logic [GPR_COUNT-1:0] CTX_HOT  = ONE_HOT0 << CTX_IDX;
  localparam logic [GPR_COUNT-1:0] RET_HOT  = ONE_HOT0 << RET_IDX;

  function automatic logic [GPR_COUNT-1:0] spanMask(input int unsigned lo, input int unsigned hi);
    logic [GPR_COUNT-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < GPR_COUNT; k++)
      if (k >= lo && k <= hi) m[k] = 1'b1;
    return m;
  endfunction

  localparam logic [GPR_COUNT-1:0] ARG_MASK  = spanMask(ARG_LO, ARG_HI);
  localparam logic [GPR_COUNT-1:0] KEEP_MASK = spanMask(KEEP_LO, KEEP_HI);

  // addresses 10..15 shift the bit out and decode to zero
  function automatic logic [GPR_COUNT-1:0] decode(input logic [ADDR_W-1:0] a);
    return ONE_HOT0 << a;
  endfunction

  logic [GPR_COUNT-1:0] validQ;
  logic wrTargetOk;
  logic wrAccept;
  logic portOkA;
  logic portOkB;
  logic exitOk;

  always_comb begin
    wrTargetOk = (wrAddr < ADDR_W'(GPR_COUNT));
    wrAccept   = wrEn && wrTargetOk && !startValid && !callDone;
    strobe.startGo = startValid;
    strobe.callGo  = callDone && !startValid;
    strobe.wrGo    = wrAccept;
    strobe.wrLow   = wrLow;
    strobe.fwdA    = wrAccept && (rdAddrA == wrAddr);
    strobe.fwdB    = wrAccept && (rdAddrB == wrAddr);
    portOkA = strobe.fwdA || (rdAddrA == ADDR_W'(FP_IDX)) || (|(validQ & decode(rdAddrA)));
    portOkB = strobe.fwdB || (rdAddrB == ADDR_W'(FP_IDX)) || (|(validQ & decode(rdAddrB)));
    exitOk  = |(validQ & RET_HOT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobe.startGo) begin
      validQ <= CTX_HOT;
    end else if (strobe.callGo) begin
      validQ <= (validQ & ~ARG_MASK) | RET_HOT;
    end else if (strobe.wrGo) begin
      validQ <= validQ | decode(wrAddr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readFault  <= 1'b0;
      writeFault <= 1'b0;
    end else begin
      readFault  <= (rdEnA && !portOkA) || (rdEnB && !portOkB) || (exitReq && !exitOk);
      writeFault <= wrEn && !wrTargetOk;
    end
  end

  AST_CALL_SCRUBS_ARGS: assert property (@(posedge clk) disable iff (!rstN)
    (callDone && !startValid) |=> ((validQ & ARG_MASK) == '0) && validQ[RET_IDX]); // R6

  AST_CALLEE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (callDone && !startValid) |=> ((validQ & KEEP_MASK) == ($past(validQ) & KEEP_MASK))); // R7

  AST_START_ONLY_CTX: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> (validQ == CTX_HOT)); // R8

  AST_WRITE_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr >= ADDR_W'(FP_IDX)) |=> writeFault); // R4

  AST_READ_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    readFault |-> $past(rdEnA || rdEnB || exitReq)); // R5

  AST_EVENT_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (startValid || callDone) |-> !strobe.wrGo); // R9
endmodule

// File: rtl/crf_datapath.sv
`timescale 1ns/1ps
module crf_datapath
  import crf_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned SUB_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [XLEN-1:0]   frameBase,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [XLEN-1:0]   wrData,
  input  logic [XLEN-1:0]   callRet,
  input  logic [XLEN-1:0]   startCtx,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [XLEN-1:0]   rdDataA,
  output logic [XLEN-1:0]   rdDataB,
  output logic [XLEN-1:0]   exitValue
);
  localparam int unsigned HI_W = XLEN - SUB_W;

  logic [XLEN-1:0] gprQ [GPR_COUNT];
  logic [XLEN-1:0] fpQ;
  logic [XLEN-1:0] wrValue;

  always_comb begin
    wrValue = strobe.wrLow ? {{HI_W{1'b0}}, wrData[SUB_W-1:0]} : wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int unsigned i = 0; i < GPR_COUNT; i++) gprQ[i] <= '0;
    end else begin
      for (int unsigned i = 0; i < GPR_COUNT; i++) begin
        if (strobe.startGo) begin
          if (i == CTX_IDX) gprQ[i] <= startCtx;
        end else if (strobe.callGo) begin
          if (i == RET_IDX) gprQ[i] <= callRet;
          else if (i >= ARG_LO && i <= ARG_HI) gprQ[i] <= '0;
        end else if (strobe.wrGo && wrAddr == ADDR_W'(i)) begin
          gprQ[i] <= wrValue;
        end
      end
    end
  end

  // frame pointer: loaded in reset, never written afterwards
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fpQ <= frameBase;
    else       fpQ <= fpQ;
  end

  function automatic logic [XLEN-1:0] pick(input logic [ADDR_W-1:0] a, input logic fwd);
    logic [XLEN-1:0] v;
    v = '0;
    for (int unsigned k = 0; k < GPR_COUNT; k++)
      if (a == ADDR_W'(k)) v = gprQ[k];
    if (a == ADDR_W'(FP_IDX)) v = fpQ;
    if (fwd) v = wrValue;
    return v;
  endfunction

  always_comb begin
    rdDataA   = pick(rdAddrA, strobe.fwdA);
    rdDataB   = pick(rdAddrB, strobe.fwdB);
    exitValue = gprQ[RET_IDX];
  end

  AST_FP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(fpQ)); // R4

  AST_RET_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.callGo |=> (gprQ[RET_IDX] == $past(callRet))); // R6

  AST_CTX_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startGo |=> (gprQ[CTX_IDX] == $past(startCtx))); // R8

  for (genvar g = 0; g < GPR_COUNT; g++) begin : g_chk
    AST_SUB_ZERO_EXT: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrGo && strobe.wrLow && wrAddr == ADDR_W'(g)) |=> (gprQ[g][XLEN-1:SUB_W] == '0)); // R3
    if (g >= ARG_LO && g <= ARG_HI) begin : g_arg
      AST_ARG_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
        strobe.callGo |=> (gprQ[g] == '0)); // R6
    end
    if (g >= KEEP_LO && g <= KEEP_HI) begin : g_keep
      AST_CALLEE_DATA: assert property (@(posedge clk) disable iff (!rstN)
        strobe.callGo |=> $stable(gprQ[g])); // R7
    end
  end
endmodule

// File: rtl/call_reg_file.sv
`timescale 1ns/1ps
module call_reg_file
  import crf_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned SUB_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [XLEN-1:0]   frameBase,
  input  logic              startValid,
  input  logic [XLEN-1:0]   startCtx,
  input  logic              callDone,
  input  logic [XLEN-1:0]   callRet,
  input  logic              wrEn,
  input  logic              wrLow,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [XLEN-1:0]   wrData,
  input  logic              rdEnA,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [XLEN-1:0]   rdDataA,
  input  logic              rdEnB,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [XLEN-1:0]   rdDataB,
  input  logic              exitReq,
  output logic [XLEN-1:0]   exitValue,
  output logic              readFault,
  output logic              writeFault
);
  strobe_t strobe;

  crf_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .callDone   (callDone),
    .wrEn       (wrEn),
    .wrLow      (wrLow),
    .wrAddr     (wrAddr),
    .rdEnA      (rdEnA),
    .rdAddrA    (rdAddrA),
    .rdEnB      (rdEnB),
    .rdAddrB    (rdAddrB),
    .exitReq    (exitReq),
    .strobe     (strobe),
    .readFault  (readFault),
    .writeFault (writeFault)
  );

  crf_datapath #(.XLEN(XLEN), .SUB_W(SUB_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .frameBase (frameBase),
    .strobe    (strobe),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .callRet   (callRet),
    .startCtx  (startCtx),
    .rdAddrA   (rdAddrA),
    .rdAddrB   (rdAddrB),
    .rdDataA   (rdDataA),
    .rdDataB   (rdDataB),
    .exitValue (exitValue)
  );
endmodule

// File: tb/test_call_reg_file.sv
`timescale 1ns/1ps
module test_call_reg_file;
  localparam logic [63:0] FB = 64'hFFFF_8800_0000_1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 0, callDone = 0, wrEn = 0, wrLow = 0, rdEnA = 0, rdEnB = 0, exitReq = 0;
  logic [63:0] startCtx = '0, callRet = '0, wrData = '0;
  logic [3:0] wrAddr = '0, rdAddrA = '0, rdAddrB = '0;
  logic [63:0] rdDataA, rdDataB, exitValue;
  logic readFault, writeFault;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] md [10];
  bit mv [10];

  always #2.5 clk = ~clk;

  call_reg_file i_call_reg_file (
    .clk(clk), .rstN(rstN), .frameBase(FB),
    .startValid(startValid), .startCtx(startCtx),
    .callDone(callDone), .callRet(callRet),
    .wrEn(wrEn), .wrLow(wrLow), .wrAddr(wrAddr), .wrData(wrData),
    .rdEnA(rdEnA), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdEnB(rdEnB), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .exitReq(exitReq), .exitValue(exitValue),
    .readFault(readFault), .writeFault(writeFault)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] expData(input int a);
    if (a == 10) return FB;
    if (a < 10) return md[a];
    return 64'h0;
  endfunction

  function automatic bit expOk(input int a);
    return (a == 10) || (a < 10 && mv[a]);
  endfunction

  function automatic logic [63:0] zx(input logic [63:0] d, input bit low);
    return low ? {32'h0, d[31:0]} : d;
  endfunction

  task automatic nextEdge();
    @(posedge clk);
    #1;
  endtask

  // read one address on port A and the mirrored address on port B
  task automatic probe(input int a, input string req);
    int b;
    b = (a + 10) % 16;
    rdEnA = 1; rdAddrA = 4'(a);
    rdEnB = 1; rdAddrB = 4'(b);
    #1;
    check(req, rdDataA, expData(a));
    check(req, rdDataB, expData(b));
    nextEdge();
    check(req, {63'h0, readFault}, {63'h0, !(expOk(a) && expOk(b))});
    rdEnA = 0; rdEnB = 0;
  endtask

  task automatic doWrite(input int a, input logic [63:0] d, input bit low, input string req);
    wrEn = 1; wrAddr = 4'(a); wrData = d; wrLow = low;
    nextEdge();
    check(req, {63'h0, writeFault}, {63'h0, (a >= 10)});
    wrEn = 0;
    if (a < 10) begin md[a] = zx(d, low); mv[a] = 1; end
  endtask

  task automatic modelCall(input logic [63:0] r);
    md[0] = r; mv[0] = 1;
    for (int k = 1; k <= 5; k++) begin md[k] = '0; mv[k] = 0; end
  endtask

  task automatic modelStart(input logic [63:0] c);
    for (int k = 0; k < 10; k++) mv[k] = 0;
    md[1] = c; mv[1] = 1;
  endtask

  task automatic doExit(input string req);
    exitReq = 1;
    #1;
    check(req, exitValue, md[0]);
    nextEdge();
    check(req, {63'h0, readFault}, {63'h0, !mv[0]});
    exitReq = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 10; k++) begin md[k] = '0; mv[k] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check("R1 readFault in reset", {63'h0, readFault}, 64'h0);
    check("R1 writeFault in reset", {63'h0, writeFault}, 64'h0);
    rstN = 1;
    nextEdge();
    check("R1 readFault idle", {63'h0, readFault}, 64'h0);
    check("R1 exit value", exitValue, 64'h0);
    for (int a = 0; a < 16; a++) probe(a, (a > 10) ? "R12 unmapped read" : "R1 reset contents");

    // enable low suppresses the fault
    rdEnA = 0; rdAddrA = 4'd3; rdEnB = 0; rdAddrB = 4'd4;
    nextEdge();
    check("R5 disabled read", {63'h0, readFault}, 64'h0);

    // write sweep, both widths, all addresses
    for (int a = 0; a < 16; a++) begin
      for (int low = 0; low < 2; low++) begin
        logic [63:0] d;
        d = 64'hA5C3_96F0_1E2D_3C4B ^ (64'(a) * 64'h0101_0101_0101_0101) ^ (64'(low) << 63);
        doWrite(a, d, low[0], (a >= 10) ? "R4 protected write" : (low ? "R3 sub write" : "R2 full write"));
        probe(a, (a >= 10) ? "R4 readback" : (low ? "R3 readback" : "R2 readback"));
      end
    end
    check("R4 writeFault clears", {63'h0, writeFault}, 64'h0);

    // same-cycle forwarding
    for (int a = 0; a < 10; a++) begin
      logic [63:0] d;
      bit low;
      d = 64'h1234_5678_9ABC_DEF0 + 64'(a) * 64'h1111_0000_0000_0011;
      low = a[0];
      wrEn = 1; wrAddr = 4'(a); wrData = d; wrLow = low;
      rdEnA = 1; rdAddrA = 4'(a);
      #1;
      check("R10 forward data", rdDataA, zx(d, low));
      nextEdge();
      check("R10 forward no fault", {63'h0, readFault}, 64'h0);
      wrEn = 0; rdEnA = 0;
      md[a] = zx(d, low); mv[a] = 1;
    end

    // call completion
    for (int a = 6; a < 10; a++) doWrite(a, 64'hC0DE_0000_0000_0000 | 64'(a), 0, "R7 setup");
    callDone = 1; callRet = 64'h8000_0000_0000_0042;
    nextEdge();
    callDone = 0;
    modelCall(64'h8000_0000_0000_0042);
    for (int a = 0; a < 10; a++) probe(a, (a == 0) ? "R6 return value" : (a <= 5 ? "R6 scrubbed arg" : "R7 callee kept"));
    doExit("R11 exit defined");

    // program start
    startValid = 1; startCtx = 64'hFFFF_0000_DEAD_BEEF;
    nextEdge();
    startValid = 0;
    modelStart(64'hFFFF_0000_DEAD_BEEF);
    for (int a = 0; a < 10; a++) probe(a, "R8 start state");
    doExit("R11 exit undefined");

    // write collides with call: write dropped, call applied
    callDone = 1; callRet = 64'h0000_0000_0000_0777;
    wrEn = 1; wrAddr = 4'd7; wrData = 64'h5555_5555_5555_5555; wrLow = 0;
    nextEdge();
    check("R9 write in call cycle no fault", {63'h0, writeFault}, 64'h0);
    callDone = 0; wrEn = 0;
    modelCall(64'h0000_0000_0000_0777);
    probe(7, "R9 write dropped");
    probe(0, "R9 call applied");

    // start collides with call and a write: only start applied
    startValid = 1; startCtx = 64'h0000_0000_0000_0C7C;
    callDone = 1; callRet = 64'hBAD0_BAD0_BAD0_BAD0;
    wrEn = 1; wrAddr = 4'd2; wrData = 64'h1;
    nextEdge();
    startValid = 0; callDone = 0; wrEn = 0;
    modelStart(64'h0000_0000_0000_0C7C);
    for (int a = 0; a < 10; a++) probe(a, "R9 start wins");
    check("R9 R0 keeps old data", exitValue, 64'h0000_0000_0000_0777);

    // exit after defining R0 with a subregister write
    doWrite(0, 64'hFFFF_FFFF_0000_0099, 1, "R11 setup");
    doExit("R11 exit after write");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule